// File: doc/BRIEF.md
# UART Interrupt Cause Controller

This block is the interrupt control slice of a classic byte-wide UART. Software writes a mask register that selects which of four interrupt classes may reach the processor. The block keeps a sticky pending flag for each raw event: received data ready, receive timeout, transmit holding buffer empty, receiver line condition and modem line change. It masks these flags and reduces them to one interrupt request line and one read-only cause byte. The cause byte names the single most urgent enabled cause.

A pending flag is set by a one-cycle event pulse and stays set until the access that services it. Servicing accesses are:
- a receive buffer read;
- a line status read;
- a modem status read;
- a transmit holding write;
- a read of the cause byte while it reports the transmit-empty cause.

Flags are held whether or not their class is enabled. Enabling a class whose flag is already set therefore raises the request at once, which software uses to force its handler to run.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0x00, the cause byte reads 0x01 and `irq` is low.
- R2: A mask write stores all eight bits, and they read back as written. Bit 0 enables data ready and timeout, bit 1 transmit empty, bit 2 line status and bit 3 modem status. Bits 7:4 have no effect on `irq` or the cause byte.
- R3: Cause bit 0 is 0 when an enabled cause is pending and 1 otherwise. `irq` is high exactly when an enabled cause is pending.
- R4: Cause bits 2:1 give the cause: 11 is line status, 10 is data ready or timeout, 01 is transmit empty and 00 is modem status.
- R5: When several enabled causes are pending, only the most urgent is reported. Line status is most urgent, then data ready/timeout, then transmit empty, then modem status.
- R6: When data ready/timeout is the reported class and a timeout is pending, cause bit 3 is 1 (cause byte 0x0C with FIFOs off). Otherwise bit 3 is 0.
- R7: Cause bits 7:6 read 11 when `fifo_en` is high and 00 when it is low. Bits 5:4 always read 0.
- R8: The transmit-empty flag clears on a transmit holding write. It also clears on a cause-byte read made while the byte reports code 01. A cause-byte read reporting any other code leaves the flag set.
- R9: A receive buffer read clears both the data-ready and timeout flags. A line status read clears the line flag, and a modem status read clears the modem flag.
- R10: Flags are latched while their class is disabled. Enabling the class later makes `irq` and the cause byte report it in the cycle after the mask write.
- R11: If an event pulse and its clearing access fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_wr | input | 1 | Mask register write strobe |
| wr_data | input | 8 | Write data for the mask register |
| mask_rdata | output | 8 | Mask register read data |
| ev_rx_ready | input | 1 | Pulse: received data available |
| ev_rx_tmo | input | 1 | Pulse: receive FIFO timeout |
| ev_tx_empty | input | 1 | Pulse: transmit holding buffer emptied |
| ev_line | input | 1 | Pulse: receiver line condition |
| ev_modem | input | 1 | Pulse: modem line change |
| fifo_en | input | 1 | FIFOs enabled status |
| rd_cause | input | 1 | Cause byte read strobe |
| rd_rxbuf | input | 1 | Receive buffer read strobe |
| rd_line | input | 1 | Line status read strobe |
| rd_modem | input | 1 | Modem status read strobe |
| wr_txhold | input | 1 | Transmit holding write strobe |
| cause | output | 8 | Read-only interrupt cause byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach from the ports is a flag that is set while its class is masked and is later unmasked. Its effect cannot be seen until the mask write, so the stimulus pulses the event with the mask clear and confirms the quiet 0x01 cause byte. It then writes the mask and looks for the cause on the very next cycle. A second hard case is the transmit-empty clear on a cause-byte read. It needs a higher-priority cause pending at the same moment to show that the read only clears the flag when code 01 is actually being reported. The stimulus therefore holds data ready and transmit empty together and reads the cause byte before the receive buffer.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic rx;
        logic tmo;
        logic thr;
        logic ls;
        logic ms;
    } irq_flags_t;

    localparam logic [3:0] CODE_LS   = 4'b0110;
    localparam logic [3:0] CODE_RX   = 4'b0100;
    localparam logic [3:0] CODE_TMO  = 4'b1100;
    localparam logic [3:0] CODE_THR  = 4'b0010;
    localparam logic [3:0] CODE_MS   = 4'b0000;
    localparam logic [3:0] CODE_NONE = 4'b0001;
endpackage

// File: rtl/uart_irq_pend.sv
module uart_irq_pend
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  irq_flags_t ev,
    input  logic       clr_rx,
    input  logic       clr_thr,
    input  logic       clr_ls,
    input  logic       clr_ms,
    output irq_flags_t flags
);
    irq_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clr_rx) begin
            flags_d.rx  = 1'b0;
            flags_d.tmo = 1'b0;
        end
        if (clr_thr) flags_d.thr = 1'b0;
        if (clr_ls)  flags_d.ls  = 1'b0;
        if (clr_ms)  flags_d.ms  = 1'b0;
        // a new event in the clearing cycle wins
        flags_d = flags_d | ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    p_rx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rx && !ev.rx && !ev.tmo) |=> (!flags.rx && !flags.tmo));
    p_thr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_thr && !ev.thr) |=> !flags.thr);
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ev.ms |=> flags.ms);
endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        enable,
    input  irq_flags_t        flags,
    input  logic              fifo_en,
    output logic [BYTE_W-1:0] cause,
    output logic              irq
);
    logic act_ls, act_rx, act_thr, act_ms;

    always_comb begin
        act_ls  = enable[2] & flags.ls;
        act_rx  = enable[0] & (flags.rx | flags.tmo);
        act_thr = enable[1] & flags.thr;
        act_ms  = enable[3] & flags.ms;
        cause   = {{2{fifo_en}}, 2'b00, CODE_NONE};
        if (act_ls)       cause[3:0] = CODE_LS;
        else if (act_rx)  cause[3:0] = flags.tmo ? CODE_TMO : CODE_RX;
        else if (act_thr) cause[3:0] = CODE_THR;
        else if (act_ms)  cause[3:0] = CODE_MS;
        irq = act_ls | act_rx | act_thr | act_ms;
    end

    p_ls_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable[2] && flags.ls) |-> (cause[3:0] == CODE_LS));
    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((enable & {flags.ms, flags.ls, flags.thr, flags.rx | flags.tmo}) == 4'b0)
        |-> (cause[0] && !irq));
    p_tmo_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cause[3] |-> (flags.tmo && cause[2:1] == 2'b10));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] mask_rdata,
    input  logic              ev_rx_ready,
    input  logic              ev_rx_tmo,
    input  logic              ev_tx_empty,
    input  logic              ev_line,
    input  logic              ev_modem,
    input  logic              fifo_en,
    input  logic              rd_cause,
    input  logic              rd_rxbuf,
    input  logic              rd_line,
    input  logic              rd_modem,
    input  logic              wr_txhold,
    output logic [BYTE_W-1:0] cause,
    output logic              irq
);
    typedef struct packed {
        logic [BYTE_W-1:0] mask;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    irq_flags_t  ev, flags;
    logic        clr_thr;

    always_comb begin
        st_d = st_q;
        if (mask_wr) st_d.mask = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_rdata = st_q.mask;
    assign ev = '{rx: ev_rx_ready, tmo: ev_rx_tmo, thr: ev_tx_empty,
                  ls: ev_line, ms: ev_modem};
    assign clr_thr = wr_txhold | (rd_cause && cause[3:0] == CODE_THR);

    uart_irq_pend u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .clr_rx  (rd_rxbuf),
        .clr_thr (clr_thr),
        .clr_ls  (rd_line),
        .clr_ms  (rd_modem),
        .flags   (flags)
    );

    uart_irq_encode u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (st_q.mask[3:0]),
        .flags   (flags),
        .fifo_en (fifo_en),
        .cause   (cause),
        .irq     (irq)
    );

    p_mask_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_rdata == $past(wr_data)));
    p_irq_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((st_q.mask[3:0] & {flags.ms, flags.ls, flags.thr, flags.rx | flags.tmo}) != 4'b0));
endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mask_wr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] mask_rdata;
    logic [4:0] ev = 5'b0;  // [0] rx ready, [1] tx empty, [2] line, [3] modem, [4] timeout
    logic       fifo_en = 1'b0;
    logic       rd_cause = 1'b0, rd_rxbuf = 1'b0, rd_line = 1'b0, rd_modem = 1'b0, wr_txhold = 1'b0;
    logic [7:0] cause;
    logic       irq;
    int         checks = 0;
    int         fails  = 0;

    always #10 clk = ~clk;

    uart_irq_ctrl u_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .wr_data(wr_data),
        .mask_rdata(mask_rdata), .ev_rx_ready(ev[0]), .ev_rx_tmo(ev[4]),
        .ev_tx_empty(ev[1]), .ev_line(ev[2]), .ev_modem(ev[3]), .fifo_en(fifo_en),
        .rd_cause(rd_cause), .rd_rxbuf(rd_rxbuf), .rd_line(rd_line),
        .rd_modem(rd_modem), .wr_txhold(wr_txhold), .cause(cause), .irq(irq)
    );

    typedef struct packed {
        logic [7:0] en;
        logic [4:0] evs;
        logic       fifo;
        logic [7:0] exp_cause;
        logic       exp_irq;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{8'h0F, 5'h00, 1'b0, 8'h01, 1'b0},  // R3 idle
        '{8'h0F, 5'h08, 1'b0, 8'h00, 1'b1},  // R4 modem
        '{8'h0F, 5'h02, 1'b0, 8'h02, 1'b1},  // R4 tx empty
        '{8'h0F, 5'h01, 1'b0, 8'h04, 1'b1},  // R4 rx ready
        '{8'h0F, 5'h04, 1'b0, 8'h06, 1'b1},  // R4 line
        '{8'h0F, 5'h1F, 1'b0, 8'h06, 1'b1},  // R5 line wins
        '{8'h0B, 5'h1F, 1'b0, 8'h0C, 1'b1},  // R6 rx class with timeout
        '{8'h0A, 5'h0F, 1'b0, 8'h02, 1'b1},  // R5 tx over modem
        '{8'h08, 5'h0F, 1'b0, 8'h00, 1'b1},  // R5 modem alone enabled
        '{8'h00, 5'h1F, 1'b0, 8'h01, 1'b0},  // R3 all masked
        '{8'hF0, 5'h1F, 1'b0, 8'h01, 1'b0},  // R2 upper bits inert
        '{8'h0F, 5'h10, 1'b1, 8'hCC, 1'b1},  // R7 fifo on, timeout only
        '{8'h0E, 5'h01, 1'b1, 8'hC1, 1'b0},  // R7 fifo on, idle
        '{8'h0F, 5'h02, 1'b1, 8'hC2, 1'b1}   // R7 fifo on, tx empty
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        rd_rxbuf = 1'b1; rd_line = 1'b1; rd_modem = 1'b1; wr_txhold = 1'b1;
        tick();
        rd_rxbuf = 1'b0; rd_line = 1'b0; rd_modem = 1'b0; wr_txhold = 1'b0;
    endtask

    task automatic set_mask(input logic [7:0] m);
        mask_wr = 1'b1; wr_data = m;
        tick();
        mask_wr = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] e);
        ev = e;
        tick();
        ev = 5'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 mask", mask_rdata, 8'h00);
        chk("R1 cause", cause, 8'h01);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        for (int i = 0; i < 14; i++) begin
            clear_all();
            fifo_en = VECS[i].fifo;
            set_mask(VECS[i].en);
            pulse(VECS[i].evs);
            chk("R2-R7 vector cause", cause, VECS[i].exp_cause);
            chk("R3 vector irq", {7'b0, irq}, {7'b0, VECS[i].exp_irq});
        end
        fifo_en = 1'b0;

        // R2 readback as written
        set_mask(8'hA5);
        chk("R2 readback", mask_rdata, 8'hA5);

        // R10 latched while masked, then enabled
        clear_all();
        set_mask(8'h00);
        pulse(5'h02);
        chk("R10 masked", cause, 8'h01);
        set_mask(8'h02);
        chk("R10 enable raises", cause, 8'h02);
        chk("R10 irq", {7'b0, irq}, 8'h01);

        // R8 cause read while reporting tx empty clears it
        rd_cause = 1'b1; tick(); rd_cause = 1'b0;
        chk("R8 read clears", cause, 8'h01);
        pulse(5'h02);
        wr_txhold = 1'b1; tick(); wr_txhold = 1'b0;
        chk("R8 write clears", cause, 8'h01);

        // R8 read while rx reported leaves tx flag
        set_mask(8'h03);
        pulse(5'h03);
        chk("R8 rx shown", cause, 8'h04);
        rd_cause = 1'b1; tick(); rd_cause = 1'b0;
        chk("R8 no clear", cause, 8'h04);
        rd_rxbuf = 1'b1; tick(); rd_rxbuf = 1'b0;
        chk("R9 rx cleared", cause, 8'h02);

        // R9 line and modem reads
        clear_all();
        set_mask(8'h0F);
        pulse(5'h0C);
        chk("R9 line shown", cause, 8'h06);
        rd_line = 1'b1; tick(); rd_line = 1'b0;
        chk("R9 line cleared", cause, 8'h00);
        rd_modem = 1'b1; tick(); rd_modem = 1'b0;
        chk("R9 modem cleared", cause, 8'h01);

        // R9 timeout cleared by receive buffer read
        pulse(5'h10);
        rd_rxbuf = 1'b1; tick(); rd_rxbuf = 1'b0;
        chk("R9 timeout cleared", cause, 8'h01);

        // R11 set wins over clear
        ev = 5'h08; rd_modem = 1'b1; tick(); ev = 5'b0; rd_modem = 1'b0;
        chk("R11 set wins", cause, 8'h00);
        chk("R11 irq", {7'b0, irq}, 8'h01);

        summary();
        $finish;
    end
endmodule